// File: doc/BRIEF.md
# Capture/Reload Sixteen-Bit Timer

This block is a sixteen-bit timer/counter built from two byte-wide halves. A sixteen-bit capture/reload register sits beside it, and one external input acts as either a trigger or a direction select. The counter advances on one of two sources. In timer use it steps once per machine-cycle strobe. In counter use it steps on each high-to-low change of an external count pin, and that pin is sampled once per strobe.

The block has three operating modes:
- **Capture:** a trigger edge copies the live count into the capture register.
- **Reload, up only:** the counter restarts from the capture register on overflow, or on a trigger edge.
- **Reload, up/down:** the trigger pin level sets the count direction. Underflow is detected when the count equals the capture register, and it reloads the all-ones value.

Software configures the block through a byte-wide register port. The block reports an overflow flag and an external-event flag as interrupt requests.

Both external pins pass through a two-flop synchroniser before use. The asynchronous reset is released through a local two-flop stage. All register and flag updates take effect on the clock edge at which the write or strobe is presented.

Top module: `tcap_timer`

## Requirements
- R1: Register map. Registers are written through `wr_*` and read combinationally through `rd_addr_i`.
  - Address 0 is control: bit0 run, bit1 capture-mode select (1 = capture, 0 = reload), bit2 trigger enable, bit3 count source (1 = external pin), bit6 external flag, bit7 overflow flag. Bits 4 and 5 read 0.
  - Address 1 is mode: bit0 enables up/down counting.
  - Addresses 2 and 3 are the counter low and high bytes.
  - Addresses 4 and 5 are the capture low and high bytes.
  - Unused addresses read 0.
  - After reset, every register reads 0 and both interrupt outputs are low, so the default direction is up.
- R2: With run set and the count source at 0, the counter advances by exactly one on each clock where `tick_i` is high, and never on a clock without it.
- R3: With the count source at 1, each strobe samples the synchronised count pin. When a high sample is followed by a low sample, one increment is pending. It appears in the counter at the next strobe, not at the strobe that saw the low sample.
- R4: While run is 0, strobes leave the counter unchanged.
- R5: In capture mode, a step from FFFFh gives 0000h and sets the overflow flag.
- R6: In capture mode with the trigger enabled, a sampled falling trigger copies the counter value held before that clock into the capture register and sets the external flag. With the trigger disabled, the capture register and the flag do not change.
- R7: In reload mode with up/down off, a step from FFFFh loads the capture register into the counter and sets the overflow flag.
- R8: In reload mode with up/down off and the trigger enabled, a sampled falling trigger loads the capture register into the counter and sets the external flag. This also applies when an overflow happens at the same strobe, and then both flags set.
- R9: In reload mode with up/down on, a synchronised trigger level of 1 counts up and a level of 0 counts down.
- R10: When counting down, a step taken while the counter equals the capture register loads FFFFh and sets the overflow flag.
- R11: With up/down on, the external flag inverts on every overflow and underflow, and `ext_irq_o` stays low regardless of that flag. In the other modes, `ext_irq_o` follows the external flag.
- R12: Flags stay set until software writes 0 to them through control. A hardware set or invert in the same clock as a control write takes precedence over the written value. `ovf_irq_o` follows the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Machine-cycle strobe, one clock wide |
| cnt_pin_i | input | 1 | External count pin, asynchronous |
| trg_pin_i | input | 1 | External trigger/direction pin, asynchronous |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data, combinational |
| ovf_irq_o | output | 1 | Overflow interrupt request |
| ext_irq_o | output | 1 | External-event interrupt request |

## Verification
The trigger action and a count step can land on the same strobe. The bench provokes this by arming the trigger pin high while the counter runs and then pulling it low at the strobe where a count also occurs.

In capture mode, the expected result is that the capture register holds the value from before the increment and the counter still advances. In reload mode, the counter is set one below overflow so that wrap and trigger coincide. The expected result is a single reload with both flags set.

A behavioural model also mirrors every clock of a long random run of strobes, pin changes and register writes. That run catches further collisions, such as a control write meeting a hardware flag set.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  // Register addresses on the byte-wide access port
  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_MODE   = 3'd1,
    RA_CNT_LO = 3'd2,
    RA_CNT_HI = 3'd3,
    RA_CAP_LO = 3'd4,
    RA_CAP_HI = 3'd5
  } reg_addr_e;

  // Control register bit positions
  localparam int CB_RUN    = 0;
  localparam int CB_CAPSEL = 1;
  localparam int CB_TRGEN  = 2;
  localparam int CB_SRC    = 3;
  localparam int CB_EXF    = 6;
  localparam int CB_OVF    = 7;

  // Mode register bit positions
  localparam int MB_UPDN   = 0;

  typedef enum logic [1:0] {
    M_CAPTURE = 2'd0,
    M_RELOAD  = 2'd1,
    M_UPDOWN  = 2'd2
  } tmode_e;

  typedef struct packed {
    logic run;
    logic cap_mode;
    logic trg_en;
    logic ext_src;
    logic updn;
  } cfg_t;

endpackage

// File: rtl/tcap_insamp.sv
module tcap_insamp #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_n;
  logic                   samp_q, samp_n;

  always_comb begin
    sync_n = {sync_q[SYNC_STAGES-2:0], pin_i};
    samp_n = tick_i ? sync_q[LAST] : samp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      samp_q <= 1'b0;
    end else begin
      sync_q <= sync_n;
      samp_q <= samp_n;
    end
  end

  assign level_o = sync_q[LAST];
  // high sample held from the previous strobe, low now at this strobe
  assign fall_o  = tick_i & samp_q & ~sync_q[LAST];

endmodule

// File: rtl/tcap_count.sv
module tcap_count
  import tcap_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  cfg_t                  cfg_i,
  input  logic                  cnt_fall_i,
  input  logic                  trg_fall_i,
  input  logic                  trg_level_i,
  input  logic [1:0]            cnt_we_i,
  input  logic [1:0]            cap_we_i,
  input  logic [HALF_W-1:0]     wdata_i,
  output logic [2*HALF_W-1:0]   cnt_o,
  output logic [2*HALF_W-1:0]   cap_o,
  output logic                  ovf_set_o,
  output logic                  exf_set_o,
  output logic                  exf_tgl_o
);

  localparam int                NHALF   = 2;
  localparam int                CNT_W   = NHALF * HALF_W;
  localparam logic [CNT_W-1:0]  CNT_MAX = '1;
  localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_hw;
  logic [CNT_W-1:0] cap_q, cap_n, cap_hw;
  logic             pend_q, pend_n;
  logic             step, trg_act, grab;
  logic             ovf_set, exf_set, exf_tgl;
  tmode_e           mode;

  always_comb begin
    if (cfg_i.cap_mode)  mode = M_CAPTURE;
    else if (cfg_i.updn) mode = M_UPDOWN;
    else                 mode = M_RELOAD;
  end

  // pending external count: detected at one strobe, applied at the next
  always_comb begin
    pend_n  = tick_i ? cnt_fall_i : pend_q;
    step    = tick_i & cfg_i.run & (cfg_i.ext_src ? pend_q : 1'b1);
    trg_act = trg_fall_i & cfg_i.trg_en;
  end

  always_comb begin
    cnt_hw  = cnt_q;
    cap_hw  = cap_q;
    ovf_set = 1'b0;
    exf_set = 1'b0;
    exf_tgl = 1'b0;
    grab    = 1'b0;
    unique case (mode)
      M_CAPTURE: begin
        if (step) begin
          cnt_hw  = cnt_q + CNT_ONE;
          ovf_set = (cnt_q == CNT_MAX);
        end
        if (trg_act) begin
          cap_hw  = cnt_q;
          grab    = 1'b1;
          exf_set = 1'b1;
        end
      end
      M_RELOAD: begin
        if (step) begin
          if (cnt_q == CNT_MAX) begin
            cnt_hw  = cap_q;
            ovf_set = 1'b1;
          end else begin
            cnt_hw  = cnt_q + CNT_ONE;
          end
        end
        if (trg_act) begin
          cnt_hw  = cap_q;
          exf_set = 1'b1;
        end
      end
      M_UPDOWN: begin
        if (step) begin
          if (trg_level_i) begin
            if (cnt_q == CNT_MAX) begin
              cnt_hw  = cap_q;
              ovf_set = 1'b1;
              exf_tgl = 1'b1;
            end else begin
              cnt_hw  = cnt_q + CNT_ONE;
            end
          end else begin
            if (cnt_q == cap_q) begin
              cnt_hw  = CNT_MAX;
              ovf_set = 1'b1;
              exf_tgl = 1'b1;
            end else begin
              cnt_hw  = cnt_q - CNT_ONE;
            end
          end
        end
      end
      default: begin
        cnt_hw = cnt_q;
      end
    endcase
  end

  // per-byte software override; a hardware capture keeps priority over capture writes
  for (genvar g = 0; g < NHALF; g++) begin : g_half
    assign cnt_n[g*HALF_W +: HALF_W] = cnt_we_i[g] ? wdata_i : cnt_hw[g*HALF_W +: HALF_W];
    assign cap_n[g*HALF_W +: HALF_W] = (cap_we_i[g] && !grab) ? wdata_i
                                                              : cap_hw[g*HALF_W +: HALF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cap_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      cap_q  <= cap_n;
      pend_q <= pend_n;
    end
  end

  assign cnt_o     = cnt_q;
  assign cap_o     = cap_q;
  assign ovf_set_o = ovf_set;
  assign exf_set_o = exf_set;
  assign exf_tgl_o = exf_tgl;

  // R2: no movement of the counter on a clock without a strobe or a write
  a_r2_tick_only : assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && cnt_we_i == 2'b00) |=> $stable(cnt_q));

  // R4: a stopped counter only moves through writes or a trigger reload
  a_r4_halt : assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i.run && cnt_we_i == 2'b00 &&
     !(trg_fall_i && cfg_i.trg_en && !cfg_i.cap_mode && !cfg_i.updn)) |=> $stable(cnt_q));

  // R5: capture-mode wrap lands on zero
  a_r5_wrap_zero : assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.cap_mode && step && cnt_q == CNT_MAX && cnt_we_i == 2'b00) |=> (cnt_q == '0));

  // R7: reload-mode overflow restarts from the capture register
  a_r7_reload_on_ovf : assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i.cap_mode && !cfg_i.updn && step && cnt_q == CNT_MAX && cnt_we_i == 2'b00)
      |=> (cnt_q == $past(cap_q)));

  // R10: down-count underflow at the capture value loads all ones
  a_r10_underflow : assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i.cap_mode && cfg_i.updn && step && !trg_level_i && cnt_q == cap_q &&
     cnt_we_i == 2'b00) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/tcap_timer.sv
module tcap_timer
  import tcap_pkg::*;
#(
  parameter int HALF_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              cnt_pin_i,
  input  logic              trg_pin_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [HALF_W-1:0] wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [HALF_W-1:0] rd_data_o,
  output logic              ovf_irq_o,
  output logic              ext_irq_o
);

  localparam int CNT_W = 2 * HALF_W;

  // reset release synchroniser
  logic [1:0] rst_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  // configuration and flags
  cfg_t cfg_q, cfg_n;
  logic ovf_q, ovf_n, exf_q, exf_n;
  logic we_ctrl, we_mode;
  logic [1:0] cnt_we, cap_we;
  logic cnt_fall, trg_fall, trg_level;
  logic ovf_set, exf_set, exf_tgl;
  logic [CNT_W-1:0] cnt_val, cap_val;

  always_comb begin
    we_ctrl = wr_en_i && (wr_addr_i == RA_CTRL);
    we_mode = wr_en_i && (wr_addr_i == RA_MODE);
    cnt_we  = {wr_en_i && (wr_addr_i == RA_CNT_HI), wr_en_i && (wr_addr_i == RA_CNT_LO)};
    cap_we  = {wr_en_i && (wr_addr_i == RA_CAP_HI), wr_en_i && (wr_addr_i == RA_CAP_LO)};
  end

  always_comb begin
    cfg_n = cfg_q;
    if (we_ctrl) begin
      cfg_n.run      = wr_data_i[CB_RUN];
      cfg_n.cap_mode = wr_data_i[CB_CAPSEL];
      cfg_n.trg_en   = wr_data_i[CB_TRGEN];
      cfg_n.ext_src  = wr_data_i[CB_SRC];
    end
    if (we_mode) cfg_n.updn = wr_data_i[MB_UPDN];

    // hardware events take precedence over a software write in the same clock
    if (ovf_set)      ovf_n = 1'b1;
    else if (we_ctrl) ovf_n = wr_data_i[CB_OVF];
    else              ovf_n = ovf_q;

    if (exf_set)      exf_n = 1'b1;
    else if (exf_tgl) exf_n = ~exf_q;
    else if (we_ctrl) exf_n = wr_data_i[CB_EXF];
    else              exf_n = exf_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cfg_q <= '0;
      ovf_q <= 1'b0;
      exf_q <= 1'b0;
    end else begin
      cfg_q <= cfg_n;
      ovf_q <= ovf_n;
      exf_q <= exf_n;
    end
  end

  tcap_insamp #(.SYNC_STAGES(SYNC_STAGES)) u_cnt_in (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick_i  (tick_i),
    .pin_i   (cnt_pin_i),
    .level_o (),
    .fall_o  (cnt_fall)
  );

  tcap_insamp #(.SYNC_STAGES(SYNC_STAGES)) u_trg_in (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick_i  (tick_i),
    .pin_i   (trg_pin_i),
    .level_o (trg_level),
    .fall_o  (trg_fall)
  );

  tcap_count #(.HALF_W(HALF_W)) u_count (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .tick_i      (tick_i),
    .cfg_i       (cfg_q),
    .cnt_fall_i  (cnt_fall),
    .trg_fall_i  (trg_fall),
    .trg_level_i (trg_level),
    .cnt_we_i    (cnt_we),
    .cap_we_i    (cap_we),
    .wdata_i     (wr_data_i),
    .cnt_o       (cnt_val),
    .cap_o       (cap_val),
    .ovf_set_o   (ovf_set),
    .exf_set_o   (exf_set),
    .exf_tgl_o   (exf_tgl)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      RA_CTRL: begin
        rd_data_o[CB_RUN]    = cfg_q.run;
        rd_data_o[CB_CAPSEL] = cfg_q.cap_mode;
        rd_data_o[CB_TRGEN]  = cfg_q.trg_en;
        rd_data_o[CB_SRC]    = cfg_q.ext_src;
        rd_data_o[CB_EXF]    = exf_q;
        rd_data_o[CB_OVF]    = ovf_q;
      end
      RA_MODE:   rd_data_o[MB_UPDN] = cfg_q.updn;
      RA_CNT_LO: rd_data_o = cnt_val[HALF_W-1:0];
      RA_CNT_HI: rd_data_o = cnt_val[CNT_W-1:HALF_W];
      RA_CAP_LO: rd_data_o = cap_val[HALF_W-1:0];
      RA_CAP_HI: rd_data_o = cap_val[CNT_W-1:HALF_W];
      default:   rd_data_o = '0;
    endcase
  end

  assign ovf_irq_o = ovf_q;
  assign ext_irq_o = exf_q & ~(~cfg_q.cap_mode & cfg_q.updn);

  // R12: a hardware overflow set survives a same-clock clearing write
  a_r12_ovf_hw_wins : assert property (@(posedge clk) disable iff (!rst_int_n)
    ovf_set |=> ovf_q);

  // R12: a hardware external-event set survives a same-clock clearing write
  a_r12_exf_hw_wins : assert property (@(posedge clk) disable iff (!rst_int_n)
    exf_set |=> exf_q);

  // R11: every up/down wrap inverts the external flag
  a_r11_exf_toggles : assert property (@(posedge clk) disable iff (!rst_int_n)
    exf_tgl |=> (exf_q != $past(exf_q)));

endmodule

// File: tb/sim_tcap_timer.sv
`timescale 1ns/1ps
module sim_tcap_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       cnt_pin = 1'b1;
  logic       trg_pin = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;
  logic       ovf_irq, ext_irq;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    ready   = 0;
  bit    done    = 0;
  string phase   = "R1";

  always #5 clk = ~clk;

  tcap_timer u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .cnt_pin_i (cnt_pin),
    .trg_pin_i (trg_pin),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .ovf_irq_o (ovf_irq),
    .ext_irq_o (ext_irq)
  );

  // ---------------- behavioural reference model ----------------
  int       m_rst;
  bit       c1, c2, cs, cp, t1, t2, ts;
  int       m_cnt, m_cap;
  bit       m_run, m_capm, m_ten, m_src, m_ud, m_ovf, m_exf;

  task automatic m_clear();
    c1 = 0; c2 = 0; cs = 0; cp = 0; t1 = 0; t2 = 0; ts = 0;
    m_cnt = 0; m_cap = 0;
    m_run = 0; m_capm = 0; m_ten = 0; m_src = 0; m_ud = 0; m_ovf = 0; m_exf = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rst = 0;
      m_clear();
    end else if (m_rst < 2) begin
      m_rst++;
      m_clear();
    end else begin
      bit cfall, tfall, lvl, stp, hw_ovf, hw_exf, hw_tgl, grabbed;
      int ncnt, ncap;
      cfall = tick && cs && !c2;
      tfall = tick && ts && !t2;
      lvl   = t2;
      stp   = tick && m_run && (m_src ? cp : 1'b1);
      if (tick) begin cs = c2; ts = t2; cp = cfall; end
      c2 = c1; c1 = cnt_pin; t2 = t1; t1 = trg_pin;
      ncnt = m_cnt; ncap = m_cap; hw_ovf = 0; hw_exf = 0; hw_tgl = 0; grabbed = 0;
      if (m_capm) begin
        if (stp) begin
          hw_ovf = (m_cnt == 65535);
          ncnt = (m_cnt + 1) % 65536;
        end
        if (tfall && m_ten) begin ncap = m_cnt; hw_exf = 1; grabbed = 1; end
      end else if (!m_ud) begin
        if (stp) begin
          if (m_cnt == 65535) begin ncnt = m_cap; hw_ovf = 1; end
          else ncnt = m_cnt + 1;
        end
        if (tfall && m_ten) begin ncnt = m_cap; hw_exf = 1; end
      end else if (stp) begin
        if (lvl) begin
          if (m_cnt == 65535) begin ncnt = m_cap; hw_ovf = 1; hw_tgl = 1; end
          else ncnt = m_cnt + 1;
        end else begin
          if (m_cnt == m_cap) begin ncnt = 65535; hw_ovf = 1; hw_tgl = 1; end
          else ncnt = m_cnt - 1;
        end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd2: ncnt = (ncnt & 16'hFF00) | wr_data;
          3'd3: ncnt = (ncnt & 16'h00FF) | (int'(wr_data) << 8);
          3'd4: if (!grabbed) ncap = (ncap & 16'hFF00) | wr_data;
          3'd5: if (!grabbed) ncap = (ncap & 16'h00FF) | (int'(wr_data) << 8);
          3'd1: m_ud = wr_data[0];
          default: ;
        endcase
      end
      if (hw_ovf) m_ovf = 1;
      else if (wr_en && wr_addr == 3'd0) m_ovf = wr_data[7];
      if (hw_exf) m_exf = 1;
      else if (hw_tgl) m_exf = !m_exf;
      else if (wr_en && wr_addr == 3'd0) m_exf = wr_data[6];
      if (wr_en && wr_addr == 3'd0) begin
        m_run = wr_data[0]; m_capm = wr_data[1]; m_ten = wr_data[2]; m_src = wr_data[3];
      end
      m_cnt = ncnt; m_cap = ncap;
    end
  end

  function automatic logic [7:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return {m_ovf, m_exf, 2'b00, m_src, m_ten, m_capm, m_run};
      3'd1: return {7'd0, m_ud};
      3'd2: return 8'(m_cnt);
      3'd3: return 8'(m_cnt >> 8);
      3'd4: return 8'(m_cap);
      3'd5: return 8'(m_cap >> 8);
      default: return 8'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison with the model
  always @(negedge clk) begin
    if (ready && !done) begin
      #2;
      chk(phase, rd_data, m_read(rd_addr));
      chk(phase, {7'd0, ovf_irq}, {7'd0, m_ovf});
      chk(phase, {7'd0, ext_irq}, {7'd0, m_exf && !(!m_capm && m_ud)});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic tk(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rchk(string tag, logic [2:0] a, logic [7:0] exp);
    @(negedge clk); rd_addr = a; #1;
    chk(tag, rd_data, exp);
  endtask

  // arm trigger high with one strobe, then fall at the next strobe
  task automatic trig_fall();
    @(negedge clk); trg_pin = 1; idle(3); tk(1);
    @(negedge clk); trg_pin = 0; idle(3); tk(1);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    idle(4);
    @(negedge clk); rst_n = 1;
    idle(6);
    ready = 1;

    // R1: reset state
    phase = "R1";
    for (int a = 0; a < 8; a++) rchk("R1", 3'(a), 8'h00);
    chk("R1", {6'd0, ovf_irq, ext_irq}, 8'h00);

    // R2: timer stepping on strobes only
    phase = "R2";
    wr(3'd0, 8'h01);
    tk(5);
    rchk("R2", 3'd2, 8'h05);
    idle(6);
    rchk("R2", 3'd2, 8'h05);

    // R4: halted counter
    phase = "R4";
    wr(3'd0, 8'h00);
    tk(3);
    rchk("R4", 3'd2, 8'h05);

    // R3: external count with one-strobe delay
    phase = "R3";
    wr(3'd0, 8'h09);
    @(negedge clk); cnt_pin = 0; idle(3);
    tk(1);
    rchk("R3", 3'd2, 8'h05);
    tk(1);
    rchk("R3", 3'd2, 8'h06);
    @(negedge clk); cnt_pin = 1; idle(3);
    tk(2);
    rchk("R3", 3'd2, 8'h06);
    @(negedge clk); cnt_pin = 0; idle(3);
    tk(2);
    rchk("R3", 3'd2, 8'h07);

    // R5: capture-mode wrap
    phase = "R5";
    wr(3'd0, 8'h00);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h03);
    tk(1);
    rchk("R5", 3'd3, 8'hFF);
    rchk("R5", 3'd0, 8'h03);
    tk(1);
    rchk("R5", 3'd2, 8'h00);
    rchk("R5", 3'd3, 8'h00);
    rchk("R5", 3'd0, 8'h83);

    // R12: clear by software, then hardware set beats a same-clock clear
    phase = "R12";
    wr(3'd0, 8'h03);
    rchk("R12", 3'd0, 8'h03);
    chk("R12", {7'd0, ovf_irq}, 8'h00);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    @(negedge clk); wr_en = 1; wr_addr = 3'd0; wr_data = 8'h03; tick = 1;
    @(negedge clk); wr_en = 0; tick = 0;
    rchk("R12", 3'd0, 8'h83);
    chk("R12", {7'd0, ovf_irq}, 8'h01);

    // R6: capture on trigger, ignored when disabled
    phase = "R6";
    wr(3'd0, 8'h06);
    wr(3'd2, 8'h34); wr(3'd3, 8'h12);
    trig_fall();
    rchk("R6", 3'd4, 8'h34);
    rchk("R6", 3'd5, 8'h12);
    rchk("R6", 3'd0, 8'h46);
    chk("R6", {7'd0, ext_irq}, 8'h01);
    wr(3'd0, 8'h02);
    wr(3'd2, 8'h78); wr(3'd3, 8'h56);
    trig_fall();
    rchk("R6", 3'd4, 8'h34);
    rchk("R6", 3'd5, 8'h12);
    rchk("R6", 3'd0, 8'h02);
    // R6: trigger and count on the same strobe
    wr(3'd0, 8'h07);
    wr(3'd2, 8'hFF); wr(3'd3, 8'h00);
    trig_fall();
    rchk("R6", 3'd4, 8'h00);
    rchk("R6", 3'd5, 8'h01);
    rchk("R6", 3'd2, 8'h01);
    rchk("R6", 3'd3, 8'h01);

    // R7: reload on overflow
    phase = "R7";
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h00); wr(3'd5, 8'hAB);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h01);
    tk(1);
    rchk("R7", 3'd2, 8'h00);
    rchk("R7", 3'd3, 8'hAB);
    rchk("R7", 3'd0, 8'h81);

    // R8: reload on trigger, alone and together with overflow
    phase = "R8";
    wr(3'd0, 8'h04);
    wr(3'd2, 8'h42); wr(3'd3, 8'h00);
    trig_fall();
    rchk("R8", 3'd2, 8'h00);
    rchk("R8", 3'd3, 8'hAB);
    rchk("R8", 3'd0, 8'h44);
    wr(3'd0, 8'h05);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    trig_fall();
    rchk("R8", 3'd2, 8'h00);
    rchk("R8", 3'd3, 8'hAB);
    rchk("R8", 3'd0, 8'hC5);

    // R10 and R11: down count with underflow at the capture value
    phase = "R10";
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h01);
    wr(3'd4, 8'h10); wr(3'd5, 8'h00);
    wr(3'd2, 8'h12); wr(3'd3, 8'h00);
    @(negedge clk); trg_pin = 0; idle(3);
    tk(1);
    rchk("R9", 3'd2, 8'h11);
    tk(1);
    rchk("R10", 3'd2, 8'h10);
    tk(1);
    rchk("R10", 3'd2, 8'hFF);
    rchk("R10", 3'd3, 8'hFF);
    rchk("R11", 3'd0, 8'hC1);
    chk("R11", {7'd0, ext_irq}, 8'h00);
    phase = "R11";
    wr(3'd0, 8'h41);
    rchk("R11", 3'd0, 8'h41);
    chk("R11", {7'd0, ext_irq}, 8'h00);

    // R9: up direction, overflow reloads and inverts the flag back
    phase = "R9";
    @(negedge clk); trg_pin = 1; idle(3);
    tk(1);
    rchk("R9", 3'd2, 8'h10);
    rchk("R9", 3'd3, 8'h00);
    rchk("R11", 3'd0, 8'h81);
    tk(1);
    rchk("R9", 3'd2, 8'h11);

    // random run against the model
    phase = "R2";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      tick = (i % 3 == 0);
      if ($urandom % 4 == 0) cnt_pin = 1'($urandom);
      if ($urandom % 6 == 0) trg_pin = 1'($urandom);
      wr_en   = ($urandom % 12 == 0);
      wr_addr = 3'($urandom % 6);
      wr_data = 8'($urandom);
      rd_addr = 3'($urandom % 6);
    end
    @(negedge clk); wr_en = 0; tick = 0;
    idle(4);
    report();
  end

endmodule